// File: doc/BRIEF.md
# Multidrop Receiver Mute Controller

This block sits beside the receiver of a UART that shares a multidrop line with several nodes. It decides whether each completed frame and each detected idle line is allowed to update the receive status flags and to request an interrupt. Software mutes the receiver when the current message is for another node. While muted, the block swallows every status update and every interrupt. It then clears the mute by itself when the chosen wake event appears on the line.

Two wake events are supported, and a select input picks one. In idle mode, an idle frame on the line ends the mute, and that idle frame raises no idle flag. In address mode, a frame whose most significant data bit is 1 ends the mute. That frame is then delivered as a normal reception. Software can also end the mute at any time by writing 0. A software set beats a hardware wake in the same cycle.

The received-frame input behaves as a valid-only stream. The deserializer cannot pause the serial line, so the block applies no back-pressure and accepts every frame in the cycle its valid is high. Downstream, `data_full_set` is the valid for `out_data`, and the data register it loads must accept it in that same cycle.

Top module: `mprm_mute_ctrl`

## Requirements
- R1: A cycle with `mute_wr`=1 and `mute_wr_val`=1 makes `muted` read 1 from the next cycle on.
- R2: While `muted` is 1, `data_full_set` and `idle_set` stay 0 for every input, except for the waking address frame of R5.
- R3: While `muted` is 1, `irq` stays 0 except in the cycle of the waking address frame of R5.
- R4: With `wake_mode`=0 (idle wake), an `idle_det` pulse while muted clears `muted` in the next cycle, and `idle_set` stays 0 in that cycle.
- R5: With `wake_mode`=1 (address wake), a frame arriving while muted whose bit DATA_W-1 is 1 clears `muted` in the next cycle. In its own cycle it raises `data_full_set`, drives `out_data` with the frame, and raises `irq` when `rdf_ie`=1.
- R6: While muted, the event that does not match the selected mode is ignored. With `wake_mode`=1, `idle_det` leaves `muted` set. With `wake_mode`=0, a frame with its top bit at 1 leaves `muted` set.
- R7: A cycle with `mute_wr`=1 and `mute_wr_val`=0 makes `muted` read 0 from the next cycle on.
- R8: A software set and a hardware wake in the same cycle leave `muted` at 1.
- R9: While not muted, each `rx_valid` raises `data_full_set` in the same cycle with `out_data`=`rx_data`, and each `idle_det` raises `idle_set` in the same cycle. `irq` equals (`data_full_set` AND `rdf_ie`) OR (`idle_set` AND `idle_ie`).
- R10: During and right after reset, `muted`, `data_full_set`, `idle_set` and `irq` are 0.
- R11: A frame that completes in the same cycle as the software set is still delivered. A frame that completes after that cycle is suppressed, even if its reception began before the mute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_valid | input | 1 | One-cycle pulse: a frame has completed |
| rx_data | input | DATA_W | Data of the completed frame |
| idle_det | input | 1 | One-cycle pulse: an idle frame has been seen on the line |
| wake_mode | input | 1 | 0 selects idle wake, 1 selects address wake |
| mute_wr | input | 1 | Software write strobe for the mute bit |
| mute_wr_val | input | 1 | Value written to the mute bit |
| rdf_ie | input | 1 | Interrupt enable for the data-full flag |
| idle_ie | input | 1 | Interrupt enable for the idle flag |
| muted | output | 1 | Current mute state |
| data_full_set | output | 1 | Gated set strobe for the data-full flag; also valid for out_data |
| out_data | output | DATA_W | Frame data delivered with data_full_set |
| idle_set | output | 1 | Gated set strobe for the idle flag |
| irq | output | 1 | Gated receive interrupt request |

## Verification
The hardest situation to reach is a set and a clear landing on the mute bit in one cycle. This happens when a software write of 1 coincides with the idle pulse or address frame that would wake the receiver. The bench drives such a coincident cycle directly in each wake mode. It also drives the mismatched wake event while muted, and a frame in the exact cycle of the software set. A long run of random inputs, with mute writes kept sparse, then covers many mixed muted and unmuted cycles against the cycle-level model.

// File: rtl/mprm_pkg.sv
package mprm_pkg;
  typedef enum logic {
    WAKE_ON_IDLE = 1'b0,
    WAKE_ON_ADDR = 1'b1
  } wake_mode_e;

  typedef struct packed {
    logic data_full;
    logic idle;
  } flag_set_t;
endpackage

// File: rtl/mprm_wake_detect.sv
module mprm_wake_detect #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mute_q,
  input  logic              wake_mode,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              idle_det,
  output logic              wake_hit,
  output logic              addr_wake
);
  import mprm_pkg::*;
  localparam int MARK_BIT = DATA_W - 1;

  wake_mode_e mode;
  logic       mark_seen;
  logic       idle_wake;

  assign mode      = wake_mode_e'(wake_mode);
  assign mark_seen = rx_valid && rx_data[MARK_BIT];
  assign addr_wake = mute_q && (mode == WAKE_ON_ADDR) && mark_seen;
  assign idle_wake = mute_q && (mode == WAKE_ON_IDLE) && idle_det;
  assign wake_hit  = addr_wake || idle_wake;

  // R6: a wake never comes from the event the mode does not select
  assert_wake_matches_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wake_hit |-> ((wake_mode && rx_valid) || (!wake_mode && idle_det)));
endmodule

// File: rtl/mprm_mute_reg.sv
module mprm_mute_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_wr,
  input  logic sw_val,
  input  logic wake_hit,
  output logic mute_q
);
  logic mute_d;

  always_comb begin
    mute_d = mute_q;
    if (sw_wr)         mute_d = sw_val;
    else if (wake_hit) mute_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mute_q <= 1'b0;
    else        mute_q <= mute_d;
  end

  assert_set_mutes_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr && sw_val) |=> mute_q);
  assert_clear_unmutes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr && !sw_val) |=> !mute_q);
  assert_set_beats_wake_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr && sw_val && wake_hit) |=> mute_q);
endmodule

// File: rtl/mprm_flag_gate.sv
module mprm_flag_gate #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mute_q,
  input  logic              addr_wake,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              idle_det,
  input  logic              rdf_ie,
  input  logic              idle_ie,
  output mprm_pkg::flag_set_t sets,
  output logic [DATA_W-1:0] out_data,
  output logic              irq
);
  logic pass;

  assign pass           = !mute_q || addr_wake;
  assign sets.data_full = rx_valid && pass;
  assign sets.idle      = idle_det && !mute_q;
  assign out_data       = sets.data_full ? rx_data : '0;
  assign irq            = (sets.data_full && rdf_ie) || (sets.idle && idle_ie);

  assert_no_idle_flag_muted_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mute_q |-> !sets.idle);
  assert_no_irq_muted_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mute_q && !addr_wake) |-> !irq);
endmodule

// File: rtl/mprm_mute_ctrl.sv
module mprm_mute_ctrl #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              idle_det,
  input  logic              wake_mode,
  input  logic              mute_wr,
  input  logic              mute_wr_val,
  input  logic              rdf_ie,
  input  logic              idle_ie,
  output logic              muted,
  output logic              data_full_set,
  output logic [DATA_W-1:0] out_data,
  output logic              idle_set,
  output logic              irq
);
  localparam int TOP = DATA_W - 1;

  logic                wake_hit;
  logic                addr_wake;
  mprm_pkg::flag_set_t sets;

  mprm_wake_detect #(.DATA_W(DATA_W)) u_wake (
    .clk(clk), .rst_n(rst_n), .mute_q(muted), .wake_mode(wake_mode),
    .rx_valid(rx_valid), .rx_data(rx_data), .idle_det(idle_det),
    .wake_hit(wake_hit), .addr_wake(addr_wake)
  );

  mprm_mute_reg u_mute (
    .clk(clk), .rst_n(rst_n), .sw_wr(mute_wr), .sw_val(mute_wr_val),
    .wake_hit(wake_hit), .mute_q(muted)
  );

  mprm_flag_gate #(.DATA_W(DATA_W)) u_gate (
    .clk(clk), .rst_n(rst_n), .mute_q(muted), .addr_wake(addr_wake),
    .rx_valid(rx_valid), .rx_data(rx_data), .idle_det(idle_det),
    .rdf_ie(rdf_ie), .idle_ie(idle_ie), .sets(sets),
    .out_data(out_data), .irq(irq)
  );

  assign data_full_set = sets.data_full;
  assign idle_set      = sets.idle;

  assert_idle_wake_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (muted && !wake_mode && idle_det && !mute_wr) |=> !muted);
  assert_idle_wake_no_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (muted && idle_det) |-> !idle_set);
  assert_addr_wake_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (muted && wake_mode && rx_valid && rx_data[TOP] && !mute_wr) |=> !muted);
  assert_addr_frame_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (muted && wake_mode && rx_valid && rx_data[TOP]) |-> (data_full_set && out_data == rx_data));
  assert_muted_frame_dropped_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (muted && !(wake_mode && rx_data[TOP])) |-> !data_full_set);
  assert_idle_ignored_addr_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (muted && wake_mode && idle_det && !rx_valid && !mute_wr) |=> muted);
  assert_unmuted_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!muted && rx_valid) |-> data_full_set);
endmodule

// File: tb/tb_mprm_mute_ctrl.sv
module tb_mprm_mute_ctrl;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rx_valid = 0, idle_det = 0, wake_mode = 0;
  logic          mute_wr = 0, mute_wr_val = 0, rdf_ie = 0, idle_ie = 0;
  logic [DW-1:0] rx_data = '0;
  logic          muted, data_full_set, idle_set, irq;
  logic [DW-1:0] out_data;

  int  checks = 0;
  int  errors = 0;
  bit  m_mute = 0;
  bit  finished = 0;

  always #4 clk = ~clk;

  mprm_mute_ctrl #(.DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .idle_det(idle_det), .wake_mode(wake_mode), .mute_wr(mute_wr),
    .mute_wr_val(mute_wr_val), .rdf_ie(rdf_ie), .idle_ie(idle_ie),
    .muted(muted), .data_full_set(data_full_set), .out_data(out_data),
    .idle_set(idle_set), .irq(irq)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one cycle: drive at negedge, compare before posedge, advance model at posedge
  task automatic cyc(input string req, input bit fv, input logic [DW-1:0] d, input bit id,
                     input bit ws, input bit wr, input bit wv, input bit rie, input bit iie);
    bit e_rdf, e_idle, e_irq;
    rx_valid = fv; rx_data = d; idle_det = id; wake_mode = ws;
    mute_wr = wr; mute_wr_val = wv; rdf_ie = rie; idle_ie = iie;
    #1;
    e_rdf  = fv && (!m_mute || (ws && d[DW-1]));
    e_idle = id && !m_mute;
    e_irq  = (e_rdf && rie) || (e_idle && iie);
    chk(req, "muted", int'(muted), int'(m_mute));
    chk(req, "data_full_set", int'(data_full_set), int'(e_rdf));
    chk(req, "idle_set", int'(idle_set), int'(e_idle));
    chk(req, "irq", int'(irq), int'(e_irq));
    if (e_rdf) chk(req, "out_data", int'(out_data), int'(d));
    @(posedge clk);
    if (wr) m_mute = wv;
    else if (m_mute && ((!ws && id) || (ws && fv && d[DW-1]))) m_mute = 0;
    @(negedge clk);
  endtask

  task automatic idle_cyc(input string req);
    cyc(req, 0, 8'h00, 0, wake_mode, 0, 0, rdf_ie, idle_ie);
  endtask

  initial begin
    #(150000 * 8);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R10: outputs quiet in reset
    chk("R10", "muted in reset", int'(muted), 0);
    chk("R10", "irq in reset", int'(irq), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    idle_cyc("R10");

    // R9: normal reception
    cyc("R9", 1, 8'h12, 0, 0, 0, 0, 1, 0);
    cyc("R9", 1, 8'h85, 0, 1, 0, 0, 0, 1);
    cyc("R9", 0, 8'h00, 1, 0, 0, 0, 0, 1);
    cyc("R9", 0, 8'h00, 1, 0, 0, 0, 1, 0);

    // R11 + R1: frame in set cycle delivered, later one dropped
    cyc("R11", 1, 8'h44, 0, 1, 1, 1, 1, 1);
    cyc("R1", 1, 8'h45, 0, 1, 0, 0, 1, 1);
    // R2/R3/R6 in address mode
    cyc("R2", 1, 8'h33, 0, 1, 0, 0, 1, 1);
    cyc("R6", 0, 8'h00, 1, 1, 0, 0, 1, 1);
    cyc("R6", 0, 8'h00, 0, 1, 0, 0, 1, 1);
    // R5: address frame wakes
    cyc("R5", 1, 8'hA5, 0, 1, 0, 0, 1, 1);
    cyc("R5", 1, 8'h21, 0, 1, 0, 0, 1, 1);

    // idle mode: R6 address frame ignored, R4 idle wakes
    cyc("R1", 0, 8'h00, 0, 0, 1, 1, 1, 1);
    cyc("R6", 1, 8'h80, 0, 0, 0, 0, 1, 1);
    cyc("R3", 1, 8'hFF, 0, 0, 0, 0, 1, 1);
    cyc("R4", 0, 8'h00, 1, 0, 0, 0, 1, 1);
    cyc("R4", 0, 8'h00, 1, 0, 0, 0, 1, 1);

    // R7: software clear
    cyc("R1", 0, 8'h00, 0, 0, 1, 1, 0, 0);
    cyc("R7", 0, 8'h00, 0, 0, 1, 0, 0, 0);
    cyc("R7", 1, 8'h07, 0, 0, 0, 0, 1, 0);

    // R8: set coincides with wake in each mode
    cyc("R1", 0, 8'h00, 0, 0, 1, 1, 0, 0);
    cyc("R8", 0, 8'h00, 1, 0, 1, 1, 1, 1);
    cyc("R8", 1, 8'hC0, 0, 1, 1, 1, 1, 1);
    cyc("R8", 0, 8'h00, 0, 1, 0, 0, 1, 1);
    cyc("R7", 0, 8'h00, 0, 1, 1, 0, 0, 0);

    // R2: random mix compared with the model every cycle
    for (int i = 0; i < 3000; i++) begin
      bit wr;
      wr = ($urandom % 8) == 0;
      cyc("R2", 1'($urandom), 8'($urandom), 1'($urandom % 3 == 0), 1'($urandom),
          wr, 1'($urandom % 3 != 0), 1'($urandom), 1'($urandom));
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule